// File: doc/BRIEF.md
# Write-Protect Status Register

This block keeps the state that decides whether a small serial memory may be modified. It holds a write-enable latch and a two-bit block-protect field, and it times the internal write cycle so it can report a write-in-progress flag. The command sequencer asks it two kinds of question. The first is whether a given array address may be written. The second is whether a whole-array fill or a status write is allowed. The sequencer also reports the events that change the latch.

The sequencer signals the start of each write cycle with a kind code. The block takes the start only when the rules allow it. On an accepted start it clears the enable latch and runs the cycle timer. For a status write it stores the new protect bits and commits them when the cycle ends. The status byte is always available to the read-status path. A master that re-reads it sees live flag values. While a status write is pending, that byte shows the new protect bits.

Top module: `wpsr_status_unit`

## Requirements
- R1: After power-on reset the status byte is 0x04: the protect field is 01, the enable latch is clear and no write is in progress.
- R2: The status byte carries write-in-progress in bit 0, the enable latch in bit 1, protect bit 0 in bit 2 and protect bit 1 in bit 3. Bits 7 to 4 are always 0.
- R3: `wel_set` sets the enable latch and `wel_clr` clears it. When both are high in the same cycle, the latch ends clear.
- R4: With the latch set, `probe_ok` reflects the protect field (bit 1, bit 0) as follows. For 00 every address is writable. For 01 addresses 0xC0 to 0xFF are blocked. For 10 addresses 0x80 to 0xFF are blocked. For 11 every address is blocked.
- R5: With the latch clear, `probe_ok`, `bulk_ok` and `sr_ok` are all 0.
- R6: A whole-array fill (kind 2) is allowed only when the latch is set and both protect bits are 0.
- R7: An accepted start raises write-in-progress for exactly WCYC_LEN cycles, starting at the next clock edge, and clears the enable latch at that same edge.
- R8: A start is ignored when a cycle is already running, when the latch is clear, when kind 2 is blocked by protection, or when the kind is 3. An ignored start leaves the latch and write-in-progress unchanged.
- R9: After an accepted status write (kind 1), the status byte shows the new protect bits for the whole cycle. Address protection keeps using the old bits until the cycle ends, and the new bits apply from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wel_set | input | 1 | Enable command executed |
| wel_clr | input | 1 | Disable command executed |
| wc_start | input | 1 | Request to begin a write cycle |
| wc_kind | input | 2 | Cycle kind: 0 array, 1 status, 2 whole array, 3 none |
| wc_sr_bits | input | 2 | New protect bits for a status write |
| probe_addr | input | ADDR_W | Array address under query |
| probe_ok | output | 1 | Address may be written |
| bulk_ok | output | 1 | Whole-array fill permitted |
| sr_ok | output | 1 | Status write permitted |
| wc_accept | output | 1 | The current start request is taken |
| wip | output | 1 | Write cycle in progress |
| status_byte | output | 8 | Byte for the read-status command |

## Verification
The bench builds the block with the default 8-bit address and a write cycle of 5 clocks. The short cycle lets it count the busy window exactly and still act inside it. It uses that window to set the latch again mid-cycle, which makes the old protect bits visible at the probe. With 8 address bits, the bench sweeps all 256 addresses under each of the four protect codes, with the latch both set and clear. It compares each result against an arithmetic range test.

// File: rtl/wpsr_pkg.sv
package wpsr_pkg;

    typedef enum logic [1:0] {
        WK_ARRAY  = 2'd0,
        WK_STATUS = 2'd1,
        WK_BULK   = 2'd2,
        WK_NONE   = 2'd3
    } wkind_e;

    localparam logic [1:0] BP_RESET = 2'b01;

    typedef struct packed {
        logic       wel;
        logic [1:0] bp;
        logic [1:0] bp_pend;
        logic       sr_pend;
    } sreg_t;

endpackage

// File: rtl/wpsr_range_guard.sv
module wpsr_range_guard #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);
    localparam int TOP = ADDR_W - 1;

    logic top_half;
    logic top_quarter;

    assign top_half    = addr[TOP];
    assign top_quarter = addr[TOP] & addr[TOP-1];

    always_comb begin
        unique case (bp)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = top_quarter;
            2'b10:   blocked = top_half;
            default: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpsr_cycle_timer.sv
module wpsr_cycle_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LAST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);  // R7
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R7
endmodule

// File: rtl/wpsr_status_unit.sv
module wpsr_status_unit
    import wpsr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int WCYC_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              wc_start,
    input  logic [1:0]        wc_kind,
    input  logic [1:0]        wc_sr_bits,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_ok,
    output logic              bulk_ok,
    output logic              sr_ok,
    output logic              wc_accept,
    output logic              wip,
    output logic [7:0]        status_byte
);
    sreg_t  st_d, st_q;
    wkind_e kind;
    logic   busy, done, blocked, permit;
    logic [1:0] bp_shown;

    assign kind = wkind_e'(wc_kind);

    wpsr_range_guard #(.ADDR_W(ADDR_W)) i_guard (
        .bp      (st_q.bp),
        .addr    (probe_addr),
        .blocked (blocked)
    );

    wpsr_cycle_timer #(.LEN(WCYC_LEN)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wc_accept),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        unique case (kind)
            WK_ARRAY, WK_STATUS: permit = st_q.wel;
            WK_BULK:             permit = st_q.wel && (st_q.bp == 2'b00);
            default:             permit = 1'b0;
        endcase
    end

    assign wc_accept = wc_start && permit && !busy;

    always_comb begin
        st_d = st_q;
        if (wel_set)   st_d.wel = 1'b1;
        if (wel_clr)   st_d.wel = 1'b0;
        if (wc_accept) st_d.wel = 1'b0;
        if (wc_accept && kind == WK_STATUS) begin
            st_d.bp_pend = wc_sr_bits;
            st_d.sr_pend = 1'b1;
        end
        if (done && st_q.sr_pend) begin
            st_d.bp      = st_q.bp_pend;
            st_d.sr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wel     <= 1'b0;
            st_q.bp      <= BP_RESET;
            st_q.bp_pend <= BP_RESET;
            st_q.sr_pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bp_shown    = st_q.sr_pend ? st_q.bp_pend : st_q.bp;
    assign probe_ok    = st_q.wel && !blocked;
    assign bulk_ok     = st_q.wel && (st_q.bp == 2'b00);
    assign sr_ok       = st_q.wel;
    assign wip         = busy;
    assign status_byte = {4'b0000, bp_shown, st_q.wel, busy};

    AST_LOCKED_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[1] |-> (!probe_ok && !bulk_ok && !sr_ok));  // R5
    AST_ACCEPT_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        wc_accept |=> !status_byte[1]);  // R7
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !wc_accept);  // R8
    AST_BULK_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_accept && wc_kind == 2'd2) |-> (bulk_ok && status_byte[3:2] == 2'b00));  // R6
    AST_BP_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wip |=> $stable(st_q.bp));  // R9
    AST_WIP_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wc_accept));  // R7
    AST_HIGH_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wel_set |=> (status_byte[7:4] == 4'h0));  // R2
endmodule

// File: tb/test_wpsr_status_unit.sv
module test_wpsr_status_unit;
    localparam int AW  = 8;
    localparam int LEN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wel_set = 1'b0, wel_clr = 1'b0, wc_start = 1'b0;
    logic [1:0] wc_kind = 2'd0, wc_sr_bits = 2'd0;
    logic [AW-1:0] probe_addr = '0;
    logic probe_ok, bulk_ok, sr_ok, wc_accept, wip;
    logic [7:0] status_byte;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wpsr_status_unit #(.ADDR_W(AW), .WCYC_LEN(LEN)) i_wpsr_status_unit (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .wc_start(wc_start), .wc_kind(wc_kind), .wc_sr_bits(wc_sr_bits),
        .probe_addr(probe_addr), .probe_ok(probe_ok), .bulk_ok(bulk_ok),
        .sr_ok(sr_ok), .wc_accept(wc_accept), .wip(wip), .status_byte(status_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit prot(input int bp, input int a);
        return (bp == 3) || (bp == 2 && a >= 128) || (bp == 1 && a >= 192);
    endfunction

    function automatic int sbyte(input int bp, input int wel, input int busy);
        return (bp << 2) | (wel << 1) | busy;
    endfunction

    task automatic pulse_set();
        @(negedge clk) wel_set = 1'b1;
        @(negedge clk) wel_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) wel_clr = 1'b1;
        @(negedge clk) wel_clr = 1'b0;
    endtask

    task automatic sweep(input int bp, input int wel);
        for (int a = 0; a < 256; a++) begin
            probe_addr = AW'(a);
            #1;
            if (wel == 1) chk("R4 probe", int'(probe_ok), int'(!prot(bp, a)));
            else          chk("R5 probe", int'(probe_ok), 0);
        end
        chk("R6 bulk", int'(bulk_ok), int'(wel == 1 && bp == 0));
        chk("R5 sr_ok", int'(sr_ok), wel);
    endtask

    task automatic status_write(input int nb, input int ob);
        int n;
        pulse_set();
        wc_start = 1'b1; wc_kind = 2'd1; wc_sr_bits = 2'(nb);
        #1 chk("R7 accept", int'(wc_accept), 1);
        @(negedge clk) wc_start = 1'b0;
        n = 0;
        while (wip && n < 100) begin
            n++;
            if (n == 1) begin
                chk("R9 byte new bp", int'(status_byte), sbyte(nb, 0, 1));
                wel_set = 1'b1;
            end
            if (n == 2) begin
                wel_set = 1'b0;
                chk("R2 byte live", int'(status_byte), sbyte(nb, 1, 1));
                probe_addr = 8'hFF;
                #1 chk("R9 old bp protects", int'(probe_ok), int'(!prot(ob, 255)));
            end
            @(negedge clk);
        end
        chk("R7 wip length", n, LEN);
        chk("R9 committed", int'(status_byte), sbyte(nb, 1, 0));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ob;
        int seq [4] = '{0, 2, 3, 1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset byte", int'(status_byte), 8'h04);
        chk("R1 reset wip", int'(wip), 0);
        sweep(1, 0);

        pulse_set();
        chk("R3 set", int'(status_byte), sbyte(1, 1, 0));
        pulse_clr();
        chk("R3 clear", int'(status_byte), sbyte(1, 0, 0));

        // start with latch clear is ignored
        wc_start = 1'b1; wc_kind = 2'd0;
        #1 chk("R8 no latch", int'(wc_accept), 0);
        @(negedge clk) wc_start = 1'b0;
        chk("R8 no latch wip", int'(wip), 0);

        ob = 1;
        foreach (seq[i]) begin
            status_write(seq[i], ob);
            sweep(seq[i], 1);
            pulse_clr();
            sweep(seq[i], 0);
            ob = seq[i];
        end

        // bulk blocked by protect field 01
        pulse_set();
        wc_start = 1'b1; wc_kind = 2'd2;
        #1 chk("R6 bulk blocked", int'(wc_accept), 0);
        @(negedge clk) wc_start = 1'b0;
        chk("R8 bulk ignored", int'(status_byte), sbyte(1, 1, 0));
        wc_start = 1'b1; wc_kind = 2'd3;
        #1 chk("R8 kind3", int'(wc_accept), 0);
        @(negedge clk) wc_start = 1'b0;
        chk("R8 kind3 ignored", int'(status_byte), sbyte(1, 1, 0));

        // array cycle, second start while busy
        wc_start = 1'b1; wc_kind = 2'd0;
        #1 chk("R7 array accept", int'(wc_accept), 1);
        @(negedge clk);
        chk("R7 array busy", int'(status_byte), sbyte(1, 0, 1));
        wel_set = 1'b1;
        @(negedge clk) wel_set = 1'b0;
        #1 chk("R8 busy reject", int'(wc_accept), 0);
        @(negedge clk) wc_start = 1'b0;
        chk("R8 busy latch kept", int'(status_byte), sbyte(1, 1, 1));
        repeat (LEN) @(negedge clk);
        chk("R7 idle after", int'(wip), 0);

        @(negedge clk) begin wel_set = 1'b1; wel_clr = 1'b1; end
        @(negedge clk) begin wel_set = 1'b0; wel_clr = 1'b0; end
        chk("R3 clear wins", int'(status_byte), sbyte(1, 0, 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule